// File: doc/BRIEF.md
# Check-Node State Update with Double-Connection Chaining

In a vertically layered min-sum decoder each check node keeps a compact state: the product of the signs of its incoming messages, the smallest and second-smallest message magnitudes, and the column indices that own those two minima. Each time a column is processed, the state of every check node that the column connects to is read, updated with the column's new bit-to-check message, and written back.

When a column group meets the same check-node group twice, one memory word receives two messages in the same sub-iteration. This block applies both messages in order. The first message is applied to the state read from memory and the result is kept in local registers. The second message is then applied to that held state, and only the final result is written back. A single connection needs one cycle. A double connection needs two cycles, and during the second cycle the block refuses new work.

The controller has two states. `ST_OPEN` accepts work. Its transition `open_to_chain` is taken when a double-connection request is accepted, and its self-loop `open_stay` covers idle cycles and single requests. `ST_CHAIN` applies the held second message and always returns to the open state through `chain_to_open`.

Top module: `cn_dd_resolver`

## Requirements
- R1: While reset is held and on the first cycle after it, `wr_en` is 0 and `in_ready` is 1.
- R2: A request is accepted when `in_valid` and `in_ready` are both 1 at a rising edge. When `dd_pair` is 0 at acceptance, `wr_en` is 1 on the following cycle and the write-back fields hold the read state updated with message A.
- R3: Update when the message column equals `rd_p0`. If the magnitude is strictly below `M1`, the new pair is (magnitude, column), (`M1`, `P1`). Otherwise it is (`M1`, `P1`), (magnitude, column).
- R4: Update when the column differs from `rd_p0` but equals `rd_p1`. If the magnitude is strictly below `M0`, the new pair is (magnitude, column), (`M0`, `P0`). Otherwise it is (`M0`, `P0`), (magnitude, column).
- R5: Update when the column owns neither minimum. If the magnitude is below `M0`, it becomes `M0` and the old `M0`/`P0` move to `M1`/`P1`. Otherwise, if it is below `M1`, it replaces `M1`/`P1`. Otherwise the state is unchanged. All comparisons are strict.
- R6: The new sign product is the old product XOR the message's previous sign XOR the new message's sign bit. The sign bit is the message MSB.
- R7: Messages are two's complement. The magnitude is the absolute value, and the most negative code maps to the all-ones magnitude.
- R8: When `dd_pair` is 1 at acceptance, `in_ready` is 0 on the next cycle. On the cycle after that, `wr_en` is 1, `in_ready` is 1, and the fields equal the update with message A followed by the update with message B, both as in R3 to R6.
- R9: On the cycle after a double-connection acceptance, `wr_en` is 0, so the intermediate state is never written.
- R10: The B message, its column and its previous sign are captured at acceptance. Input changes and `in_valid` during the not-ready cycle do not alter the written result.
- R11: `wr_en` is a single-cycle pulse. It is 0 on any cycle not preceded by an acceptance or a chain step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| dd_pair | input | 1 | Request carries two messages for one check word |
| rd_sign | input | 1 | Stored sign product |
| rd_m0 | input | MSG_W-1 | Stored smallest magnitude |
| rd_m1 | input | MSG_W-1 | Stored second-smallest magnitude |
| rd_p0 | input | IDX_W | Column owning the smallest magnitude |
| rd_p1 | input | IDX_W | Column owning the second-smallest magnitude |
| ta_msg | input | MSG_W | First message, two's complement |
| ta_col | input | IDX_W | First message column |
| ta_prev_sign | input | 1 | Sign this edge had previously |
| tb_msg | input | MSG_W | Second message, two's complement |
| tb_col | input | IDX_W | Second message column |
| tb_prev_sign | input | 1 | Sign the second edge had previously |
| wr_en | output | 1 | Write-back strobe |
| wr_sign | output | 1 | New sign product |
| wr_m0 | output | MSG_W-1 | New smallest magnitude |
| wr_m1 | output | MSG_W-1 | New second-smallest magnitude |
| wr_p0 | output | IDX_W | New owner of the smallest magnitude |
| wr_p1 | output | IDX_W | New owner of the second-smallest magnitude |

## Verification
The bench builds the block with `MSG_W` = 5 and `IDX_W` = 3. With only eight column values, random columns often match `P0` or `P1`, so all three update cases occur many times. Four-bit magnitudes produce frequent ties with the stored minima, and the most negative code appears often enough to exercise saturation. Double-connection requests are mixed with single ones, and the not-ready cycle is filled with live, conflicting inputs to show that they are ignored.

// File: rtl/cn_dd_pkg.sv
package cn_dd_pkg;

    // Controller states.
    typedef enum logic [0:0] {
        ST_OPEN  = 1'b0,
        ST_CHAIN = 1'b1
    } dd_state_e;

    // Which stored minimum the incoming column owns.
    typedef enum logic [1:0] {
        CASE_OWN_P0  = 2'd0,
        CASE_OWN_P1  = 2'd1,
        CASE_FOREIGN = 2'd2
    } own_case_e;

endpackage

// File: rtl/cn_msg_mag.sv
module cn_msg_mag #(
    parameter int MSG_W = 6,
    parameter int MAG_W = MSG_W - 1
) (
    input  logic [MSG_W-1:0] msg,
    output logic [MAG_W-1:0] mag,
    output logic             sgn
);
    logic [MSG_W-1:0] negated;
    logic             is_floor;

    always_comb begin
        sgn      = msg[MSG_W-1];
        negated  = -msg;
        is_floor = msg[MSG_W-1] && (msg[MSG_W-2:0] == '0);
        if (is_floor)
            mag = '1;
        else if (sgn)
            mag = negated[MAG_W-1:0];
        else
            mag = msg[MAG_W-1:0];
    end
endmodule

// File: rtl/cn_state_update.sv
module cn_state_update
    import cn_dd_pkg::*;
#(
    parameter int MSG_W = 6,
    parameter int IDX_W = 8,
    parameter int MAG_W = MSG_W - 1
) (
    input  logic             cur_sign,
    input  logic [MAG_W-1:0] cur_m0,
    input  logic [MAG_W-1:0] cur_m1,
    input  logic [IDX_W-1:0] cur_p0,
    input  logic [IDX_W-1:0] cur_p1,
    input  logic [MSG_W-1:0] msg,
    input  logic [IDX_W-1:0] col,
    input  logic             prev_sign,
    output logic             nxt_sign,
    output logic [MAG_W-1:0] nxt_m0,
    output logic [MAG_W-1:0] nxt_m1,
    output logic [IDX_W-1:0] nxt_p0,
    output logic [IDX_W-1:0] nxt_p1
);
    logic [MAG_W-1:0] mag;
    logic             new_sgn;
    own_case_e        sel;
    logic             below_m0;
    logic             below_m1;

    cn_msg_mag #(.MSG_W(MSG_W), .MAG_W(MAG_W)) u_mag (
        .msg (msg),
        .mag (mag),
        .sgn (new_sgn)
    );

    // Index comparators pick the ownership case; P0 takes priority.
    always_comb begin
        if (col == cur_p0)
            sel = CASE_OWN_P0;
        else if (col == cur_p1)
            sel = CASE_OWN_P1;
        else
            sel = CASE_FOREIGN;
    end

    // Magnitude comparators against both stored minima.
    assign below_m0 = (mag < cur_m0);
    assign below_m1 = (mag < cur_m1);

    always_comb begin
        nxt_sign = cur_sign ^ prev_sign ^ new_sgn;
        nxt_m0   = cur_m0;
        nxt_m1   = cur_m1;
        nxt_p0   = cur_p0;
        nxt_p1   = cur_p1;
        unique case (sel)
            CASE_OWN_P0: begin
                if (below_m1) begin
                    nxt_m0 = mag;    nxt_p0 = col;
                    nxt_m1 = cur_m1; nxt_p1 = cur_p1;
                end else begin
                    nxt_m0 = cur_m1; nxt_p0 = cur_p1;
                    nxt_m1 = mag;    nxt_p1 = col;
                end
            end
            CASE_OWN_P1: begin
                if (below_m0) begin
                    nxt_m0 = mag;    nxt_p0 = col;
                    nxt_m1 = cur_m0; nxt_p1 = cur_p0;
                end else begin
                    nxt_m0 = cur_m0; nxt_p0 = cur_p0;
                    nxt_m1 = mag;    nxt_p1 = col;
                end
            end
            CASE_FOREIGN: begin
                if (below_m0) begin
                    nxt_m0 = mag;    nxt_p0 = col;
                    nxt_m1 = cur_m0; nxt_p1 = cur_p0;
                end else if (below_m1) begin
                    nxt_m1 = mag;    nxt_p1 = col;
                end
            end
            default: begin
                nxt_m0 = cur_m0;
            end
        endcase
    end
endmodule

// File: rtl/cn_dd_fsm.sv
module cn_dd_fsm
    import cn_dd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      dd_pair,
    output logic      in_ready,
    output logic      take,
    output logic      chain_start,
    output logic      out_load,
    output dd_state_e state
);
    dd_state_e state_nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OPEN;
        else
            state <= state_nxt;
    end

    // Transitions: open_stay, open_to_chain, chain_to_open.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN:  state_nxt = (in_valid && dd_pair) ? ST_CHAIN : ST_OPEN;
            ST_CHAIN: state_nxt = ST_OPEN;
            default:  state_nxt = ST_OPEN;
        endcase
    end

    // Outputs.
    always_comb begin
        in_ready    = 1'b0;
        take        = 1'b0;
        chain_start = 1'b0;
        out_load    = 1'b0;
        unique case (state)
            ST_OPEN: begin
                in_ready    = 1'b1;
                take        = in_valid;
                chain_start = in_valid && dd_pair;
                out_load    = in_valid && !dd_pair;
            end
            ST_CHAIN: begin
                out_load    = 1'b1;
            end
            default: begin
                in_ready    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cn_dd_resolver.sv
module cn_dd_resolver
    import cn_dd_pkg::*;
#(
    parameter int MSG_W = 6,
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 dd_pair,
    input  logic                 rd_sign,
    input  logic [MSG_W-2:0]     rd_m0,
    input  logic [MSG_W-2:0]     rd_m1,
    input  logic [IDX_W-1:0]     rd_p0,
    input  logic [IDX_W-1:0]     rd_p1,
    input  logic [MSG_W-1:0]     ta_msg,
    input  logic [IDX_W-1:0]     ta_col,
    input  logic                 ta_prev_sign,
    input  logic [MSG_W-1:0]     tb_msg,
    input  logic [IDX_W-1:0]     tb_col,
    input  logic                 tb_prev_sign,
    output logic                 wr_en,
    output logic                 wr_sign,
    output logic [MSG_W-2:0]     wr_m0,
    output logic [MSG_W-2:0]     wr_m1,
    output logic [IDX_W-1:0]     wr_p0,
    output logic [IDX_W-1:0]     wr_p1
);
    localparam int MAG_W = MSG_W - 1;

    dd_state_e        state;
    logic             take;
    logic             chain_start;
    logic             out_load;

    // Held intermediate state and held second message.
    logic             h_sign;
    logic [MAG_W-1:0] h_m0, h_m1;
    logic [IDX_W-1:0] h_p0, h_p1;
    logic [MSG_W-1:0] h_msg;
    logic [IDX_W-1:0] h_col;
    logic             h_prev;

    // Shared update unit operands and result.
    logic             u_sign;
    logic [MAG_W-1:0] u_m0, u_m1;
    logic [IDX_W-1:0] u_p0, u_p1;
    logic [MSG_W-1:0] u_msg;
    logic [IDX_W-1:0] u_col;
    logic             u_prev;
    logic             r_sign;
    logic [MAG_W-1:0] r_m0, r_m1;
    logic [IDX_W-1:0] r_p0, r_p1;

    cn_dd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .dd_pair     (dd_pair),
        .in_ready    (in_ready),
        .take        (take),
        .chain_start (chain_start),
        .out_load    (out_load),
        .state       (state)
    );

    // Operand select: memory word with A when open, held word with B when chaining.
    always_comb begin
        if (state == ST_CHAIN) begin
            u_sign = h_sign; u_m0 = h_m0; u_m1 = h_m1; u_p0 = h_p0; u_p1 = h_p1;
            u_msg  = h_msg;  u_col = h_col; u_prev = h_prev;
        end else begin
            u_sign = rd_sign; u_m0 = rd_m0; u_m1 = rd_m1; u_p0 = rd_p0; u_p1 = rd_p1;
            u_msg  = ta_msg;  u_col = ta_col; u_prev = ta_prev_sign;
        end
    end

    cn_state_update #(.MSG_W(MSG_W), .IDX_W(IDX_W), .MAG_W(MAG_W)) u_upd (
        .cur_sign  (u_sign),
        .cur_m0    (u_m0),
        .cur_m1    (u_m1),
        .cur_p0    (u_p0),
        .cur_p1    (u_p1),
        .msg       (u_msg),
        .col       (u_col),
        .prev_sign (u_prev),
        .nxt_sign  (r_sign),
        .nxt_m0    (r_m0),
        .nxt_m1    (r_m1),
        .nxt_p0    (r_p0),
        .nxt_p1    (r_p1)
    );

    // Local hold registers for the first step of a double connection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_sign <= 1'b0; h_m0 <= '0; h_m1 <= '0; h_p0 <= '0; h_p1 <= '0;
            h_msg  <= '0;   h_col <= '0; h_prev <= 1'b0;
        end else if (chain_start) begin
            h_sign <= r_sign; h_m0 <= r_m0; h_m1 <= r_m1; h_p0 <= r_p0; h_p1 <= r_p1;
            h_msg  <= tb_msg; h_col <= tb_col; h_prev <= tb_prev_sign;
        end
    end

    // Write-back registers and strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_sign <= 1'b0; wr_m0 <= '0; wr_m1 <= '0; wr_p0 <= '0; wr_p1 <= '0;
        end else begin
            wr_en <= out_load;
            if (out_load) begin
                wr_sign <= r_sign; wr_m0 <= r_m0; wr_m1 <= r_m1;
                wr_p0   <= r_p0;   wr_p1 <= r_p1;
            end
        end
    end

    logic unused_take;
    assign unused_take = take;
endmodule

// File: rtl/cn_dd_resolver_chk.sv
module cn_dd_resolver_chk #(
    parameter int MSG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             dd_pair,
    input logic             wr_en,
    input logic [MSG_W-1:0] ta_msg,
    input logic [MSG_W-2:0] wr_m0
);
    logic             acc_single;
    logic             acc_double;
    logic [MSG_W-2:0] a_abs;
    logic [MSG_W-1:0] a_neg;

    assign acc_single = in_valid && in_ready && !dd_pair;
    assign acc_double = in_valid && in_ready && dd_pair;
    assign a_neg      = -ta_msg;
    assign a_abs      = (ta_msg[MSG_W-1] && ta_msg[MSG_W-2:0] == '0) ? '1 :
                        (ta_msg[MSG_W-1] ? a_neg[MSG_W-2:0] : ta_msg[MSG_W-2:0]);

    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_single |=> wr_en);

    p_chain_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_double |=> !in_ready);

    p_chain_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (wr_en && in_ready));

    p_no_mid_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_double |=> !wr_en);

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !wr_en);

    p_min_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_single |=> (wr_m0 <= $past(a_abs)));
endmodule

bind cn_dd_resolver cn_dd_resolver_chk #(.MSG_W(MSG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .dd_pair  (dd_pair),
    .wr_en    (wr_en),
    .ta_msg   (ta_msg),
    .wr_m0    (wr_m0)
);

// File: tb/tb_cn_dd_resolver.sv
module tb_cn_dd_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int MSG_W = 5;
    localparam int IDX_W = 3;
    localparam int MAG_W = MSG_W - 1;
    localparam int ST_W  = 1 + 2*MAG_W + 2*IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, dd_pair = 1'b0;
    logic rd_sign = 1'b0;
    logic [MAG_W-1:0] rd_m0 = '0, rd_m1 = '0;
    logic [IDX_W-1:0] rd_p0 = '0, rd_p1 = '0;
    logic [MSG_W-1:0] ta_msg = '0, tb_msg = '0;
    logic [IDX_W-1:0] ta_col = '0, tb_col = '0;
    logic ta_prev_sign = 1'b0, tb_prev_sign = 1'b0;
    logic wr_en, wr_sign;
    logic [MAG_W-1:0] wr_m0, wr_m1;
    logic [IDX_W-1:0] wr_p0, wr_p1;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cn_dd_resolver #(.MSG_W(MSG_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .dd_pair(dd_pair), .rd_sign(rd_sign), .rd_m0(rd_m0), .rd_m1(rd_m1),
        .rd_p0(rd_p0), .rd_p1(rd_p1), .ta_msg(ta_msg), .ta_col(ta_col),
        .ta_prev_sign(ta_prev_sign), .tb_msg(tb_msg), .tb_col(tb_col),
        .tb_prev_sign(tb_prev_sign), .wr_en(wr_en), .wr_sign(wr_sign),
        .wr_m0(wr_m0), .wr_m1(wr_m1), .wr_p0(wr_p0), .wr_p1(wr_p1)
    );

    function automatic logic [MAG_W-1:0] ref_mag(input logic [MSG_W-1:0] v);
        logic [MSG_W-1:0] n;
        n = -v;
        if (v == {1'b1, {(MSG_W-1){1'b0}}}) return '1;
        return v[MSG_W-1] ? n[MAG_W-1:0] : v[MAG_W-1:0];
    endfunction

    // State packing: {sign, m0, m1, p0, p1}
    function automatic logic [ST_W-1:0] ref_update(input logic [ST_W-1:0] st,
            input logic [MSG_W-1:0] msg, input logic [IDX_W-1:0] col, input logic ps);
        logic s; logic [MAG_W-1:0] m0, m1, mg; logic [IDX_W-1:0] p0, p1;
        logic [MAG_W-1:0] n0, n1; logic [IDX_W-1:0] q0, q1;
        {s, m0, m1, p0, p1} = st;
        mg = ref_mag(msg);
        n0 = m0; n1 = m1; q0 = p0; q1 = p1;
        if (col == p0) begin
            if (mg < m1) begin n0 = mg; q0 = col; n1 = m1; q1 = p1; end
            else         begin n0 = m1; q0 = p1;  n1 = mg; q1 = col; end
        end else if (col == p1) begin
            if (mg < m0) begin n0 = mg; q0 = col; n1 = m0; q1 = p0; end
            else         begin n0 = m0; q0 = p0;  n1 = mg; q1 = col; end
        end else begin
            if (mg < m0)      begin n0 = mg; q0 = col; n1 = m0; q1 = p0; end
            else if (mg < m1) begin n1 = mg; q1 = col; end
        end
        return {s ^ ps ^ msg[MSG_W-1], n0, n1, q0, q1};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ST_W-1:0] out_word();
        return {wr_sign, wr_m0, wr_m1, wr_p0, wr_p1};
    endfunction

    task automatic scramble();
        rd_sign = 1'($urandom); rd_m0 = MAG_W'($urandom); rd_m1 = MAG_W'($urandom);
        rd_p0 = IDX_W'($urandom); rd_p1 = IDX_W'($urandom);
        ta_msg = MSG_W'($urandom); tb_msg = MSG_W'($urandom);
        ta_col = IDX_W'($urandom); tb_col = IDX_W'($urandom);
        ta_prev_sign = 1'($urandom); tb_prev_sign = 1'($urandom);
        dd_pair = 1'($urandom);
    endtask

    task automatic op(input bit dd, input logic [ST_W-1:0] st,
            input logic [MSG_W-1:0] am, input logic [IDX_W-1:0] ac, input logic aps,
            input logic [MSG_W-1:0] bm, input logic [IDX_W-1:0] bc, input logic bps,
            input string tag);
        logic [ST_W-1:0] e;
        e = ref_update(st, am, ac, aps);
        if (dd) e = ref_update(e, bm, bc, bps);
        @(negedge clk);
        {rd_sign, rd_m0, rd_m1, rd_p0, rd_p1} = st;
        ta_msg = am; ta_col = ac; ta_prev_sign = aps;
        tb_msg = bm; tb_col = bc; tb_prev_sign = bps;
        dd_pair = dd; in_valid = 1'b1;
        @(negedge clk);
        if (!dd) begin
            chk(wr_en == 1'b1, {tag, " R2 strobe"}, 32'(wr_en), 1);
            chk(out_word() == e, {tag, " R2 word"}, 32'(out_word()), 32'(e));
            in_valid = 1'b0;
        end else begin
            chk(wr_en == 1'b0, {tag, " R9 no mid write"}, 32'(wr_en), 0);
            chk(in_ready == 1'b0, {tag, " R8 busy"}, 32'(in_ready), 0);
            scramble();   // R10: live inputs while not ready
            in_valid = 1'b1;
            @(negedge clk);
            chk(wr_en == 1'b1, {tag, " R8 strobe"}, 32'(wr_en), 1);
            chk(out_word() == e, {tag, " R8 R10 word"}, 32'(out_word()), 32'(e));
            chk(in_ready == 1'b1, {tag, " R8 ready back"}, 32'(in_ready), 1);
            in_valid = 1'b0;
        end
        @(negedge clk);
        chk(wr_en == 1'b0, {tag, " R11 pulse"}, 32'(wr_en), 0);
    endtask

    function automatic logic [ST_W-1:0] mk(input logic s, input int m0, input int m1,
            input int p0, input int p1);
        return {s, MAG_W'(m0), MAG_W'(m1), IDX_W'(p0), IDX_W'(p1)};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        tests++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [ST_W-1:0] base;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R1 strobe in reset", 32'(wr_en), 0);
        chk(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0, "R1 strobe after reset", 32'(wr_en), 0);
        chk(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 1);

        base = mk(1'b0, 3, 7, 2, 5);
        // R3: column owns P0
        op(0, base, 5'd5, 3'd2, 0, 0, 0, 0, "R3 below M1");
        op(0, base, 5'd9, 3'd2, 0, 0, 0, 0, "R3 above M1");
        op(0, base, 5'd7, 3'd2, 0, 0, 0, 0, "R3 tie M1");
        // R4: column owns P1
        op(0, base, 5'd1, 3'd5, 0, 0, 0, 0, "R4 below M0");
        op(0, base, 5'd6, 3'd5, 0, 0, 0, 0, "R4 above M0");
        // R5: foreign column
        op(0, base, 5'd1, 3'd0, 0, 0, 0, 0, "R5 new min");
        op(0, base, 5'd4, 3'd0, 0, 0, 0, 0, "R5 new second");
        op(0, base, 5'd7, 3'd0, 0, 0, 0, 0, "R5 tie M1 unchanged");
        op(0, base, 5'd3, 3'd0, 0, 0, 0, 0, "R5 tie M0");
        // R6: sign product
        op(0, base, 5'd2, 3'd6, 1, 0, 0, 0, "R6 prev neg new pos");
        op(0, base, 5'h1E, 3'd6, 0, 0, 0, 0, "R6 new neg");
        // R7: most negative code saturates
        op(0, mk(1'b0, 14, 15, 1, 2), 5'h10, 3'd0, 0, 0, 0, 0, "R7 floor code");
        op(0, mk(1'b0, 6, 9, 1, 2), 5'h1B, 3'd0, 0, 0, 0, 0, "R7 neg five");
        // R8: double connections
        op(1, base, 5'd1, 3'd2, 0, 5'd0, 3'd4, 1, "R8 chain new min twice");
        op(1, base, 5'h1C, 3'd5, 1, 5'd9, 3'd2, 0, "R8 chain owner swap");
        op(1, mk(1'b1, 15, 15, 0, 1), 5'h10, 3'd3, 1, 5'h10, 3'd4, 1, "R8 chain floor");

        for (int i = 0; i < 400; i++) begin
            op(1'($urandom), mk(1'($urandom), int'($urandom_range(0,15)), int'($urandom_range(0,15)),
               int'($urandom_range(0,7)), int'($urandom_range(0,7))),
               MSG_W'($urandom), IDX_W'($urandom), 1'($urandom),
               MSG_W'($urandom), IDX_W'($urandom), 1'($urandom), "rand R2 R3 R4 R5 R8");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule